// File: doc/BRIEF.md
# Reconfigurable Fuzzy Rule Inference Datapath

This block turns up to three 8-bit feature values into one signed confidence number with a Sugeno-style fuzzy inference. Every feature is looked up in a small bank of programmable membership tables, one table per (input, membership) pair. A rule selector routes one grade from each active input into a rule node. The rule's strength is the smallest of those grades. Each rule also holds a linear consequent. The output is the strength-weighted average of all rule consequents.

A two-bit configuration, latched with each start, picks how many inputs (two or three) and how many memberships per input (two or three) take part. This gives 4, 8, 9 or 27 live rules. The rule nodes are visited one per cycle. The normalisation runs on a bit-serial divider, so a result appears a fixed number of cycles after start. Membership tables and consequent coefficients are loaded through a plain write port before inference starts.

Top module: `fuzzy_rule_engine`

## Requirements
- R1: After reset `busy`, `done` and `confidence` are all zero, and every membership table entry and every coefficient reads as zero.
- R2: `cfg_mode` is sampled with `start`. Bit 1 selects three inputs (1) or two inputs (0). Bit 0 selects three memberships per input (1) or two (0). The number of live rules is m to the power n: 4, 9, 8 and 27 for codes 0, 1, 2 and 3.
- R3: The grade of input i (a=0, b=1, c=2) for membership k is read from table number 3·i+k at the entry given by bits [7:2] of that feature. Table entries are written with `grade_we`, selecting the table by `grade_fn` and the entry by `grade_idx`. Table numbers 9 and above are ignored.
- R4: Rule r takes membership (r mod m) of input a, membership ((r div m) mod m) of input b and, with three inputs, membership ((r div m²) mod m) of input c. Its strength is the minimum of those grades.
- R5: Rules with r ≥ m^n have zero strength. With two inputs, feature c affects neither any strength nor any consequent.
- R6: The consequent of rule r is p·a + q·b + t·c + s, with c taken as zero when only two inputs are live. The four signed 8-bit coefficients are written with `coef_we` at `coef_rule`, where `coef_term` 0, 1, 2 and 3 select p, q, t and s. Writes to rule numbers 27 and above are ignored.
- R7: `confidence` equals Σ(strength·consequent) divided by Σ(strength), truncated toward zero. It is 0 when every strength is zero.
- R8: `done` pulses for exactly one cycle, 60 rising edges after the edge that accepts `start`. `confidence` changes only on that edge and holds until the next result.
- R9: `busy` is high from the edge after an accepted start up to and including the edge that raises `done`. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inference on the present features and configuration |
| cfg_mode | input | 2 | Input count and membership count selection |
| feat_a | input | 8 | Feature input a |
| feat_b | input | 8 | Feature input b |
| feat_c | input | 8 | Feature input c |
| grade_we | input | 1 | Membership table write strobe |
| grade_fn | input | 4 | Table number for a grade write |
| grade_idx | input | 6 | Table entry for a grade write |
| coef_we | input | 1 | Coefficient write strobe |
| coef_rule | input | 5 | Rule number for a coefficient write |
| coef_term | input | 2 | Coefficient selector within a rule |
| wr_data | input | 8 | Write data for both memories |
| busy | output | 1 | Inference in progress |
| done | output | 1 | One-cycle result strobe |
| confidence | output | 24 | Signed inference result |

## Verification
The bench attacks the routing of grades to rules in every configuration. A wrong digit split in the rule selector would pair the wrong memberships and move the weighted average. It changes coefficients of rules outside the live set and swings feature c under a two-input mode. A design that let dead rules or the unused input leak would shift the result. Negative weighted sums and an all-zero strength set probe the divider: floor rounding or a missing zero guard shows up as an off-by-one or a garbage value. A second start inside a busy window checks that the first result and its single done pulse survive.

// File: rtl/fre_pkg.sv
package fre_pkg;
    localparam int FEAT_W    = 8;
    localparam int GRADE_W   = 8;
    localparam int LUT_AW    = 6;
    localparam int N_IN      = 3;
    localparam int N_MF      = 3;
    localparam int N_FN      = N_IN * N_MF;
    localparam int FN_W      = $clog2(N_FN);
    localparam int MAX_RULES = N_MF ** N_IN;
    localparam int RULE_W    = $clog2(MAX_RULES);
    localparam int COEF_W    = 8;
    localparam int N_TERM    = N_IN + 1;
    localparam int TERM_W    = $clog2(N_TERM);
    localparam int SUMW_W    = $clog2(MAX_RULES * ((1 << GRADE_W) - 1) + 1);
    localparam int CONS_W    = COEF_W + FEAT_W + 3;
    localparam int ACC_W     = CONS_W + GRADE_W + RULE_W;
    localparam int CONF_W    = 24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_DIV  = 2'd2
    } fre_state_e;

    typedef logic [N_MF-1:0][GRADE_W-1:0] grade_row_t;

    typedef struct packed {
        fre_state_e                     st;
        logic [1:0]                     cfg;
        logic [N_IN-1:0][FEAT_W-1:0]    feat;
        logic [RULE_W-1:0]              rule;
        logic [SUMW_W-1:0]              sum_w;
        logic signed [ACC_W-1:0]        sum_wy;
        logic signed [CONF_W-1:0]       conf;
        logic                           done;
    } fre_core_t;
endpackage

// File: rtl/fre_grade_bank.sv
module fre_grade_bank #(
    parameter int P_IN  = 3,
    parameter int P_MF  = 3,
    parameter int P_GW  = 8,
    parameter int P_AW  = 6,
    localparam int L_FN    = P_IN * P_MF,
    localparam int L_FNW   = $clog2(L_FN),
    localparam int L_DEPTH = 1 << P_AW
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [L_FNW-1:0]                   wr_fn,
    input  logic [P_AW-1:0]                    wr_idx,
    input  logic [P_GW-1:0]                    wr_data,
    input  logic [P_IN-1:0][P_AW-1:0]          feat_idx,
    output logic [P_IN-1:0][P_MF-1:0][P_GW-1:0] grade
);
    logic [P_GW-1:0] tbl_q [L_FN][L_DEPTH];
    logic [P_GW-1:0] tbl_d [L_FN][L_DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (wr_fn < L_FNW'(L_FN))) begin
            tbl_d[wr_fn][wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: '0};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar gi = 0; gi < P_IN; gi++) begin : g_in
        for (genvar gm = 0; gm < P_MF; gm++) begin : g_mf
            assign grade[gi][gm] = tbl_q[gi*P_MF+gm][feat_idx[gi]];
        end
    end
endmodule

// File: rtl/fre_coef_bank.sv
module fre_coef_bank #(
    parameter int P_RULES = 27,
    parameter int P_TERMS = 4,
    parameter int P_CW    = 8,
    localparam int L_RW   = $clog2(P_RULES),
    localparam int L_TW   = $clog2(P_TERMS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [L_RW-1:0]               wr_rule,
    input  logic [L_TW-1:0]               wr_term,
    input  logic [P_CW-1:0]               wr_data,
    input  logic [L_RW-1:0]               rd_rule,
    output logic [P_TERMS-1:0][P_CW-1:0]  coef
);
    logic [P_CW-1:0] tbl_q [P_RULES][P_TERMS];
    logic [P_CW-1:0] tbl_d [P_RULES][P_TERMS];
    logic            rd_ok;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (wr_rule < L_RW'(P_RULES))) begin
            tbl_d[wr_rule][wr_term] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: '0};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ok = (rd_rule < L_RW'(P_RULES));

    for (genvar gt = 0; gt < P_TERMS; gt++) begin : g_term
        assign coef[gt] = rd_ok ? tbl_q[rd_rule][gt] : '0;
    end
endmodule

// File: rtl/fre_seq_divider.sv
module fre_seq_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 13,
    parameter int Q_W   = 24,
    localparam int CNT_W = $clog2(NUM_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [NUM_W-1:0] num,
    input  logic [DEN_W-1:0]        den,
    output logic                    valid,
    output logic signed [Q_W-1:0]   quot
);
    typedef struct packed {
        logic                   busy;
        logic [CNT_W-1:0]       cnt;
        logic [NUM_W-1:0]       quo;
        logic [DEN_W-1:0]       rem;
        logic [DEN_W-1:0]       den;
        logic                   neg;
        logic                   zero;
        logic                   valid;
        logic signed [Q_W-1:0]  res;
    } div_regs_t;

    div_regs_t       div_q, div_d;
    logic [DEN_W:0]  sh;
    logic [Q_W-1:0]  mag;

    always_comb begin
        div_d       = div_q;
        div_d.valid = 1'b0;
        sh          = '0;
        mag         = '0;
        if (load) begin
            div_d.busy = 1'b1;
            div_d.cnt  = '0;
            div_d.quo  = num[NUM_W-1] ? (~num + NUM_W'(1)) : num;
            div_d.rem  = '0;
            div_d.den  = den;
            div_d.neg  = num[NUM_W-1];
            div_d.zero = (den == '0);
        end else if (div_q.busy) begin
            sh        = {div_q.rem, div_q.quo[NUM_W-1]};
            div_d.quo = {div_q.quo[NUM_W-2:0], 1'b0};
            if (sh >= {1'b0, div_q.den}) begin
                div_d.rem    = DEN_W'(sh - {1'b0, div_q.den});
                div_d.quo[0] = 1'b1;
            end else begin
                div_d.rem = sh[DEN_W-1:0];
            end
            div_d.cnt = div_q.cnt + 1'b1;
            if (div_q.cnt == CNT_W'(NUM_W - 1)) begin
                div_d.busy  = 1'b0;
                div_d.valid = 1'b1;
                mag         = div_d.quo[Q_W-1:0];
                if (div_q.zero) begin
                    div_d.res = '0;
                end else if (div_q.neg) begin
                    div_d.res = -$signed(mag);
                end else begin
                    div_d.res = $signed(mag);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign valid = div_q.valid;
    assign quot  = div_q.res;

    AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.busy && !div_q.zero) |-> (div_q.rem < div_q.den)); // R7
endmodule

// File: rtl/fuzzy_rule_engine.sv
module fuzzy_rule_engine
    import fre_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               cfg_mode,
    input  logic [FEAT_W-1:0]        feat_a,
    input  logic [FEAT_W-1:0]        feat_b,
    input  logic [FEAT_W-1:0]        feat_c,
    input  logic                     grade_we,
    input  logic [FN_W-1:0]          grade_fn,
    input  logic [LUT_AW-1:0]        grade_idx,
    input  logic                     coef_we,
    input  logic [RULE_W-1:0]        coef_rule,
    input  logic [TERM_W-1:0]        coef_term,
    input  logic [GRADE_W-1:0]       wr_data,
    output logic                     busy,
    output logic                     done,
    output logic signed [CONF_W-1:0] confidence
);
    fre_core_t core_q, core_d;

    logic [N_IN-1:0][N_MF-1:0][GRADE_W-1:0] grades;
    logic [N_IN-1:0][LUT_AW-1:0]            feat_idx;
    logic [N_TERM-1:0][COEF_W-1:0]          coef;

    logic [RULE_W-1:0]         n_rules;
    logic [1:0]                dig_a, dig_b, dig_c;
    logic [GRADE_W-1:0]        g_a, g_b, g_c, strength;
    logic signed [CONS_W-1:0]  c_p, c_q, c_t, c_s, f_a, f_b, f_c, cons;
    logic signed [ACC_W-1:0]   w_ext, y_ext, wy;
    logic                      div_load, div_valid;
    logic signed [CONF_W-1:0]  div_quot;

    function automatic logic [GRADE_W-1:0] pick(input grade_row_t row, input logic [1:0] d);
        case (d)
            2'd0:    return row[0];
            2'd1:    return row[1];
            2'd2:    return row[2];
            default: return '0;
        endcase
    endfunction

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_idx
        assign feat_idx[gi] = core_q.feat[gi][FEAT_W-1 -: LUT_AW];
    end

    fre_grade_bank #(
        .P_IN (N_IN),
        .P_MF (N_MF),
        .P_GW (GRADE_W),
        .P_AW (LUT_AW)
    ) grade_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (grade_we),
        .wr_fn    (grade_fn),
        .wr_idx   (grade_idx),
        .wr_data  (wr_data),
        .feat_idx (feat_idx),
        .grade    (grades)
    );

    fre_coef_bank #(
        .P_RULES (MAX_RULES),
        .P_TERMS (N_TERM),
        .P_CW    (COEF_W)
    ) coef_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_rule (coef_rule),
        .wr_term (coef_term),
        .wr_data (wr_data),
        .rd_rule (core_q.rule),
        .coef    (coef)
    );

    fre_seq_divider #(
        .NUM_W (ACC_W),
        .DEN_W (SUMW_W),
        .Q_W   (CONF_W)
    ) divider_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .num   (core_d.sum_wy),
        .den   (core_d.sum_w),
        .valid (div_valid),
        .quot  (div_quot)
    );

    // rule selector: digits of the rule number in base m pick one grade per input
    always_comb begin
        case (core_q.cfg)
            2'd0:    n_rules = RULE_W'(4);
            2'd1:    n_rules = RULE_W'(9);
            2'd2:    n_rules = RULE_W'(8);
            default: n_rules = RULE_W'(MAX_RULES);
        endcase
        if (core_q.cfg[0]) begin
            dig_a = 2'(core_q.rule % RULE_W'(3));
            dig_b = 2'((core_q.rule / RULE_W'(3)) % RULE_W'(3));
            dig_c = 2'((core_q.rule / RULE_W'(9)) % RULE_W'(3));
        end else begin
            dig_a = {1'b0, core_q.rule[0]};
            dig_b = {1'b0, core_q.rule[1]};
            dig_c = {1'b0, core_q.rule[2]};
        end
        g_a = pick(grades[0], dig_a);
        g_b = pick(grades[1], dig_b);
        g_c = pick(grades[2], dig_c);
        strength = (g_a < g_b) ? g_a : g_b;
        if (core_q.cfg[1] && (g_c < strength)) begin
            strength = g_c;
        end
        if (core_q.rule >= n_rules) begin
            strength = '0;
        end
    end

    // linear consequent and weighted product
    always_comb begin
        c_p  = $signed(coef[0]);
        c_q  = $signed(coef[1]);
        c_t  = $signed(coef[2]);
        c_s  = $signed(coef[3]);
        f_a  = $signed({1'b0, core_q.feat[0]});
        f_b  = $signed({1'b0, core_q.feat[1]});
        f_c  = core_q.cfg[1] ? $signed({1'b0, core_q.feat[2]}) : '0;
        cons = c_p * f_a + c_q * f_b + c_t * f_c + c_s;
        w_ext = $signed({1'b0, strength});
        y_ext = cons;
        wy    = w_ext * y_ext;
    end

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        div_load    = 1'b0;
        case (core_q.st)
            ST_IDLE: begin
                if (start) begin
                    core_d.st     = ST_ACC;
                    core_d.cfg    = cfg_mode;
                    core_d.feat   = {feat_c, feat_b, feat_a};
                    core_d.rule   = '0;
                    core_d.sum_w  = '0;
                    core_d.sum_wy = '0;
                end
            end
            ST_ACC: begin
                core_d.sum_w  = core_q.sum_w + SUMW_W'(strength);
                core_d.sum_wy = core_q.sum_wy + wy;
                if (core_q.rule == RULE_W'(MAX_RULES - 1)) begin
                    core_d.st = ST_DIV;
                    div_load  = 1'b1;
                end else begin
                    core_d.rule = core_q.rule + 1'b1;
                end
            end
            ST_DIV: begin
                if (div_valid) begin
                    core_d.conf = div_quot;
                    core_d.done = 1'b1;
                    core_d.st   = ST_IDLE;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy       = (core_q.st != ST_IDLE);
    assign done       = core_q.done;
    assign confidence = core_q.conf;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_CONF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(confidence)); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R9
    AST_SUMW_NONDEC: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_ACC && $past(core_q.st == ST_ACC)) |-> (core_q.sum_w >= $past(core_q.sum_w))); // R4
    AST_RULE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_ACC) |-> (core_q.rule < RULE_W'(MAX_RULES))); // R5
    AST_DEAD_RULE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == ST_ACC && core_q.rule >= n_rules) |=> (core_q.sum_w == $past(core_q.sum_w))); // R5
endmodule

// File: tb/fuzzy_rule_engine_tb.sv
module fuzzy_rule_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [7:0]  feat_a = '0, feat_b = '0, feat_c = '0;
    logic        grade_we = 1'b0;
    logic [3:0]  grade_fn = '0;
    logic [5:0]  grade_idx = '0;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_rule = '0;
    logic [1:0]  coef_term = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, done;
    logic signed [23:0] confidence;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int gm [9][64];
    int cm [27][4];
    int left = 0;
    int pend = 0;
    int e_conf = 0;
    bit e_done = 1'b0;

    always #5 clk = ~clk;

    fuzzy_rule_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .feat_a(feat_a), .feat_b(feat_b), .feat_c(feat_c),
        .grade_we(grade_we), .grade_fn(grade_fn), .grade_idx(grade_idx),
        .coef_we(coef_we), .coef_rule(coef_rule), .coef_term(coef_term),
        .wr_data(wr_data), .busy(busy), .done(done), .confidence(confidence)
    );

    function automatic int ref_conf(int cfg, int fa, int fb, int fc);
        int n, m, nr, w, y, z;
        longint sw, swy;
        n = (cfg >= 2) ? 3 : 2;
        m = (cfg % 2 == 1) ? 3 : 2;
        nr = m ** n;
        sw = 0;
        swy = 0;
        for (int r = 0; r < nr; r++) begin
            w = gm[r % m][fa / 4];
            if (gm[3 + (r / m) % m][fb / 4] < w) w = gm[3 + (r / m) % m][fb / 4];
            if (n == 3 && gm[6 + (r / (m * m)) % m][fc / 4] < w) w = gm[6 + (r / (m * m)) % m][fc / 4];
            z = (n == 3) ? fc : 0;
            y = cm[r][0] * fa + cm[r][1] * fb + cm[r][2] * z + cm[r][3];
            sw += w;
            swy += longint'(w) * longint'(y);
        end
        if (sw == 0) return 0;
        return int'(swy / sw);
    endfunction

    always @(posedge clk) begin
        int old;
        if (!rst_n) begin
            left = 0; e_done = 1'b0; e_conf = 0; pend = 0;
            for (int i = 0; i < 9; i++) for (int j = 0; j < 64; j++) gm[i][j] = 0;
            for (int i = 0; i < 27; i++) for (int j = 0; j < 4; j++) cm[i][j] = 0;
        end else begin
            old = left;
            if (grade_we && grade_fn < 9) gm[grade_fn][grade_idx] = int'(grade_idx) * 0 + int'(wr_data);
            if (coef_we && coef_rule < 27) cm[coef_rule][coef_term] = int'($signed(wr_data));
            e_done = 1'b0;
            if (old > 0) begin
                left = old - 1;
                if (left == 0) begin
                    e_done = 1'b1;
                    e_conf = pend;
                end
            end
            if (old == 0 && start) begin
                left = 60;
                pend = ref_conf(int'(cfg_mode), int'(feat_a), int'(feat_b), int'(feat_c));
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            check("R8 done per cycle", int'(done), int'(e_done));
            check("R9 busy per cycle", int'(busy), (left > 0) ? 1 : 0);
            check("R7 confidence per cycle", int'(confidence), e_conf);
        end
    end

    task automatic wr_grade(input int fn, input int idx, input int val);
        grade_we = 1'b1; grade_fn = fn[3:0]; grade_idx = idx[5:0]; wr_data = val[7:0];
        @(negedge clk);
        grade_we = 1'b0;
    endtask

    task automatic wr_coef(input int rule, input int term, input int val);
        coef_we = 1'b1; coef_rule = rule[4:0]; coef_term = term[1:0]; wr_data = val[7:0];
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic run_case(input int cfg, input int fa, input int fb, input int fc,
                            input string tag, output int got);
        int exp_v, k;
        exp_v = ref_conf(cfg, fa, fb, fc);
        @(negedge clk);
        start = 1'b1; cfg_mode = cfg[1:0];
        feat_a = fa[7:0]; feat_b = fb[7:0]; feat_c = fc[7:0];
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check("R8 done latency", k, 61);
        check(tag, int'(confidence), exp_v);
        got = int'(confidence);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int g1, g2, g3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        check("R1 confidence after reset", int'(confidence), 0);
        mon_on = 1'b1;
        // R1/R7: cleared tables give zero strength everywhere
        run_case(3, 200, 100, 50, "R1 cleared tables give zero", g1);
        check("R7 all strengths zero", g1, 0);

        // load membership tables and coefficients
        for (int fn = 0; fn < 9; fn++)
            for (int i = 0; i < 64; i++)
                wr_grade(fn, i, ((i + fn) % 13 == 0) ? 0 : (fn * 53 + i * 29 + 7) % 256);
        for (int r = 0; r < 27; r++)
            for (int t = 0; t < 4; t++)
                wr_coef(r, t, ((r * 7 + t * 19 + 3) % 61) - 30);

        // R2/R4/R6: every configuration with several feature patterns
        for (int cfg = 0; cfg < 4; cfg++) begin
            run_case(cfg, 17, 240, 99, "R2 configuration sweep", g1);
            run_case(cfg, 255, 3, 128, "R4 rule routing", g1);
            run_case(cfg, 64, 130, 255, "R6 consequent", g1);
        end

        // R3: rewrite one grade and see it taken up
        wr_grade(0, 130 / 4, 255);
        wr_grade(4, 70 / 4, 1);
        run_case(3, 130, 70, 10, "R3 rewritten grade", g1);
        wr_grade(12, 5, 77);
        run_case(3, 130, 70, 10, "R3 table number out of range ignored", g2);
        check("R3 out of range write has no effect", g2, g1);

        // R5: dead rules and the unused input do nothing
        run_case(0, 90, 180, 20, "R5 two inputs baseline", g1);
        wr_coef(20, 0, 127);
        wr_coef(20, 3, -128);
        wr_coef(5, 2, 100);
        run_case(0, 90, 180, 230, "R5 dead rules and input c", g2);
        check("R5 result unchanged", g2, g1);

        // R6: writes beyond rule 26 are dropped
        run_case(3, 40, 41, 42, "R6 before dropped write", g1);
        wr_coef(29, 3, 120);
        wr_coef(31, 0, -100);
        run_case(3, 40, 41, 42, "R6 after dropped write", g2);
        check("R6 dropped coefficient write", g2, g1);

        // R7: negative weighted sum, truncation toward zero
        for (int r = 0; r < 27; r++) wr_coef(r, 0, -100 + r);
        for (int r = 0; r < 27; r++) wr_coef(r, 3, 37 - r);
        run_case(3, 250, 77, 201, "R7 negative average", g1);
        check("R7 sign of result", (g1 < 0) ? 1 : 0, 1);
        run_case(1, 9, 211, 0, "R7 negative average two inputs", g1);

        // R9: second start while busy is ignored
        g3 = ref_conf(2, 150, 60, 33);
        @(negedge clk);
        start = 1'b1; cfg_mode = 2'd2; feat_a = 8'd150; feat_b = 8'd60; feat_c = 8'd33;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 busy during inference", int'(busy), 1);
        start = 1'b1; cfg_mode = 2'd3; feat_a = 8'd1; feat_b = 8'd2; feat_c = 8'd3;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check("R9 first result kept", int'(confidence), g3);
        @(negedge clk);
        check("R9 no second done", int'(done), 0);
        check("R9 idle after result", int'(busy), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule